// File: doc/BRIEF.md
# Input Power-Loss Detector

This block monitors the high-side DC supply through a stream of ADC readings. The input is nominally 12 V with a ±10% tolerance. The block decides whether the supply has really gone away or has only dipped for a moment. Each valid reading is compared against a programmable threshold. Software or strap logic places that threshold slightly under the lower edge of the tolerance band. A loss is confirmed only when a parameterised number of valid readings in a row fall under that level. A single reading at or above the level discards the run, so short interruptions are filtered out.

On confirmation the block does two things at the same clock edge. It pulls the active-low configuration-reset output low, which drops the programmable device to its static current. It also raises a one-cycle request that starts the shutdown sequencer. The condition then latches, together with a sticky status flag. A supply that recovers during the shutdown cannot bring the system back up until the block's own synchronous reset is applied.

Top module: `pwr_loss_guard`

## Requirements
- R1: After synchronous reset, `cfg_rst_n_o` is 1, `shdn_req_o` is 0 and `loss_seen_o` is 0.
- R2: A valid reading counts as low only when `smp_data_i` is strictly less than `thresh_i` (unsigned). A valid reading equal to or above the threshold clears the run of low readings. A threshold of 0 therefore never trips.
- R3: A loss is confirmed on the `CONFIRM_N`-th consecutive valid low reading. The outputs change at the very clock edge that samples that reading, and not earlier.
- R4: A run of fewer than `CONFIRM_N` low readings followed by a valid non-low reading confirms nothing. The next confirmation again needs a full `CONFIRM_N` fresh low readings.
- R5: Cycles with `smp_vld_i` at 0 neither advance nor clear the run, whatever `smp_data_i` holds.
- R6: On confirmation, `cfg_rst_n_o` goes low in the same cycle that `shdn_req_o` is high.
- R7: `shdn_req_o` is high for exactly one cycle per confirmed event. Further low readings after the event cause no second pulse.
- R8: Once confirmed, `cfg_rst_n_o` stays low until reset, regardless of later readings.
- R9: `loss_seen_o` becomes 1 with the event and stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_vld_i | input | 1 | ADC reading present this cycle |
| smp_data_i | input | ADC_W | ADC reading of the input supply |
| thresh_i | input | ADC_W | Loss threshold; readings below it are low |
| cfg_rst_n_o | output | 1 | Active-low configuration reset to the device |
| shdn_req_o | output | 1 | One-cycle shutdown request to the sequencer |
| loss_seen_o | output | 1 | Sticky loss-event flag |

## Verification
The assertions assume that `thresh_i` is steady while a run of readings is being counted. The checker's own run counter compares each reading against the threshold of that same cycle, so a threshold that moved mid-run would make its view of the run differ from the design's. The assertions also assume `smp_data_i` is known whenever `smp_vld_i` is high. The stimulus changes the threshold only while reset is held. It drives every reading, including those on idle cycles, with defined values. Idle cycles deliberately carry values that would count as low, to expose any counting of unqualified data.

// File: rtl/pwr_loss_pkg.sv
package pwr_loss_pkg;

    // Trip controller states
    typedef enum logic [1:0] {
        PLG_ARMED = 2'd0,   // watching readings
        PLG_FIRE  = 2'd1,   // first cycle of a confirmed loss
        PLG_HOLD  = 2'd2    // loss latched, waiting for reset
    } plg_state_e;

    // Output bundle driven from the controller state
    typedef struct packed {
        logic cfg_rst_n;
        logic shdn_req;
        logic seen;
    } plg_out_t;

    localparam plg_out_t PLG_OUT_IDLE = '{cfg_rst_n: 1'b1, shdn_req: 1'b0, seen: 1'b0};

    function automatic plg_out_t plg_decode(input plg_state_e st);
        plg_out_t o;
        o = PLG_OUT_IDLE;
        case (st)
            PLG_FIRE: begin
                o.cfg_rst_n = 1'b0;
                o.shdn_req  = 1'b1;
                o.seen      = 1'b1;
            end
            PLG_HOLD: begin
                o.cfg_rst_n = 1'b0;
                o.seen      = 1'b1;
            end
            default: o = PLG_OUT_IDLE;
        endcase
        return o;
    endfunction

    function automatic logic plg_is_armed(input plg_state_e st);
        return st == PLG_ARMED;
    endfunction

endpackage

// File: rtl/plg_low_run.sv
module plg_low_run #(
    parameter int ADC_W     = 12,
    parameter int CONFIRM_N = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en_i,
    input  logic             smp_vld_i,
    input  logic [ADC_W-1:0] smp_data_i,
    input  logic [ADC_W-1:0] thresh_i,
    output logic             confirm_o
);
    localparam int CNT_W = (CONFIRM_N > 1) ? $clog2(CONFIRM_N) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(CONFIRM_N - 1);

    logic             below;
    logic [CNT_W-1:0] run_q;
    logic [CNT_W-1:0] run_d;

    assign below = smp_data_i < thresh_i;

    always_comb begin
        run_d = run_q;
        if (en_i && smp_vld_i) begin
            if (!below)
                run_d = '0;
            else if (run_q != LAST)
                run_d = run_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            run_q <= '0;
        else
            run_q <= run_d;
    end

    assign confirm_o = en_i & smp_vld_i & below & (run_q == LAST);

endmodule

// File: rtl/plg_trip_fsm.sv
module plg_trip_fsm
    import pwr_loss_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       confirm_i,
    output plg_state_e state_o
);
    plg_state_e st_q;
    plg_state_e st_d;

    always_comb begin
        st_d = st_q;
        case (st_q)
            PLG_ARMED: if (confirm_i) st_d = PLG_FIRE;
            PLG_FIRE:  st_d = PLG_HOLD;
            PLG_HOLD:  st_d = PLG_HOLD;
            default:   st_d = PLG_HOLD;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            st_q <= PLG_ARMED;
        else
            st_q <= st_d;
    end

    assign state_o = st_q;

endmodule

// File: rtl/pwr_loss_guard.sv
module pwr_loss_guard
    import pwr_loss_pkg::*;
#(
    parameter int ADC_W     = 12,
    parameter int CONFIRM_N = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             smp_vld_i,
    input  logic [ADC_W-1:0] smp_data_i,
    input  logic [ADC_W-1:0] thresh_i,
    output logic             cfg_rst_n_o,
    output logic             shdn_req_o,
    output logic             loss_seen_o
);
    plg_state_e state;
    plg_out_t   outs;
    logic       confirm;

    plg_low_run #(
        .ADC_W    (ADC_W),
        .CONFIRM_N(CONFIRM_N)
    ) u_run (
        .clk       (clk),
        .rst       (rst),
        .en_i      (plg_is_armed(state)),
        .smp_vld_i (smp_vld_i),
        .smp_data_i(smp_data_i),
        .thresh_i  (thresh_i),
        .confirm_o (confirm)
    );

    plg_trip_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .confirm_i(confirm),
        .state_o  (state)
    );

    assign outs        = plg_decode(state);
    assign cfg_rst_n_o = outs.cfg_rst_n;
    assign shdn_req_o  = outs.shdn_req;
    assign loss_seen_o = outs.seen;

endmodule

// File: rtl/pwr_loss_guard_chk.sv
module pwr_loss_guard_chk #(
    parameter int ADC_W     = 12,
    parameter int CONFIRM_N = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             smp_vld_i,
    input logic [ADC_W-1:0] smp_data_i,
    input logic [ADC_W-1:0] thresh_i,
    input logic             cfg_rst_n_o,
    input logic             shdn_req_o,
    input logic             loss_seen_o
);
    localparam int RW = $clog2(CONFIRM_N + 1);
    localparam logic [RW-1:0] FULL = RW'(CONFIRM_N);

    // independent tally of consecutive valid low readings, saturating
    logic [RW-1:0] seen_run;
    always_ff @(posedge clk) begin
        if (rst)
            seen_run <= '0;
        else if (smp_vld_i)
            seen_run <= (smp_data_i < thresh_i) ? ((seen_run == FULL) ? FULL : seen_run + 1'b1) : '0;
    end

    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        shdn_req_o |=> !shdn_req_o); // R7
    AST_REQ_WITH_RESET: assert property (@(posedge clk) disable iff (rst)
        shdn_req_o |-> !cfg_rst_n_o); // R6
    AST_ENTRY_HAS_REQ: assert property (@(posedge clk) disable iff (rst)
        $fell(cfg_rst_n_o) |-> shdn_req_o); // R6
    AST_LOSS_LATCHED: assert property (@(posedge clk) disable iff (rst)
        !cfg_rst_n_o |=> !cfg_rst_n_o); // R8
    AST_FLAG_TRACKS: assert property (@(posedge clk) disable iff (rst)
        loss_seen_o |=> loss_seen_o); // R9
    AST_FLAG_WITH_EVENT: assert property (@(posedge clk) disable iff (rst)
        $rose(loss_seen_o) |-> shdn_req_o); // R9
    AST_IDLE_NO_TRIP: assert property (@(posedge clk) disable iff (rst)
        (!smp_vld_i && cfg_rst_n_o) |=> cfg_rst_n_o); // R5
    AST_HIGH_NO_TRIP: assert property (@(posedge clk) disable iff (rst)
        (smp_vld_i && !(smp_data_i < thresh_i) && cfg_rst_n_o) |=> cfg_rst_n_o); // R2
    AST_NO_EARLY_TRIP: assert property (@(posedge clk) disable iff (rst)
        $fell(cfg_rst_n_o) |-> (seen_run == FULL)); // R3

endmodule

bind pwr_loss_guard pwr_loss_guard_chk #(
    .ADC_W    (ADC_W),
    .CONFIRM_N(CONFIRM_N)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .smp_vld_i  (smp_vld_i),
    .smp_data_i (smp_data_i),
    .thresh_i   (thresh_i),
    .cfg_rst_n_o(cfg_rst_n_o),
    .shdn_req_o (shdn_req_o),
    .loss_seen_o(loss_seen_o)
);

// File: tb/sim_pwr_loss_guard.sv
module sim_pwr_loss_guard;
    localparam int CLK_PERIOD = 10;
    localparam int W = 6;
    localparam int N = 4;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         vld = 1'b0;
    logic [W-1:0] data = '0;
    logic [W-1:0] thr = '0;
    logic         cfg_n, req, seen;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwr_loss_guard #(.ADC_W(W), .CONFIRM_N(N)) u0 (
        .clk(clk), .rst(rst), .smp_vld_i(vld), .smp_data_i(data),
        .thresh_i(thr), .cfg_rst_n_o(cfg_n), .shdn_req_o(req), .loss_seen_o(seen)
    );

    task automatic chk(input string tag, input logic [2:0] act, input logic [2:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: {cfg_n,req,seen} actual=%b expected=%b", tag, act, exp);
        end
    endtask

    // drive at negedge, one posedge passes, return at the next negedge
    task automatic push(input logic v, input logic [W-1:0] d);
        vld = v;
        data = d;
        @(negedge clk);
    endtask

    task automatic do_reset(input logic [W-1:0] t);
        rst = 1'b1;
        vld = 1'b0;
        thr = t;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        do_reset(6'd32);
        chk("R1 reset state", {cfg_n, req, seen}, 3'b100);

        // R2/R3/R6: exhaustive readings against several thresholds
        for (int ti = 0; ti < 4; ti++) begin
            logic [W-1:0] t;
            t = (ti == 0) ? 6'd0 : (ti == 1) ? 6'd17 : (ti == 2) ? 6'd40 : 6'd63;
            for (int d = 0; d < 64; d++) begin
                logic lo;
                lo = (d < int'(t));
                do_reset(t);
                for (int k = 0; k < N - 1; k++) push(1'b1, W'(d));
                chk("R3 no trip before count", {cfg_n, req, seen}, 3'b100);
                push(1'b1, W'(d));
                chk("R2 R6 compare and trip", {cfg_n, req, seen}, lo ? 3'b011 : 3'b100);
                push(1'b0, W'(d));
                chk("R7 pulse ends", {cfg_n, req, seen}, lo ? 3'b001 : 3'b100);
            end
        end

        // R4: short runs broken by a non-low reading (equal to threshold)
        for (int l = 0; l < N; l++) begin
            do_reset(6'd32);
            for (int k = 0; k < l; k++) push(1'b1, 6'd10);
            push(1'b1, 6'd32);
            chk("R4 run broken", {cfg_n, req, seen}, 3'b100);
            for (int k = 0; k < N - 1; k++) push(1'b1, 6'd5);
            chk("R4 fresh run not yet full", {cfg_n, req, seen}, 3'b100);
            push(1'b1, 6'd5);
            chk("R4 fresh run trips", {cfg_n, req, seen}, 3'b011);
        end

        // R5: idle cycles with low and high data between valid lows
        for (int g = 1; g < 4; g++) begin
            do_reset(6'd32);
            for (int k = 0; k < N - 1; k++) begin
                push(1'b1, 6'd3);
                for (int j = 0; j < g; j++) push(1'b0, (j % 2 == 0) ? 6'd0 : 6'd60);
            end
            chk("R5 idle cycles ignored", {cfg_n, req, seen}, 3'b100);
            push(1'b1, 6'd3);
            chk("R5 trips on Nth valid", {cfg_n, req, seen}, 3'b011);
        end

        // R8/R9/R7: latched after event, no second pulse
        do_reset(6'd32);
        for (int k = 0; k < N; k++) push(1'b1, 6'd1);
        chk("R6 event", {cfg_n, req, seen}, 3'b011);
        for (int k = 0; k < 8; k++) begin
            push(1'b1, 6'd63);
            chk("R8 R9 latched on recovery", {cfg_n, req, seen}, 3'b001);
        end
        for (int k = 0; k < 2 * N; k++) begin
            push(1'b1, 6'd0);
            chk("R7 no second pulse", {cfg_n, req, seen}, 3'b001);
        end
        do_reset(6'd32);
        chk("R1 reset clears latch", {cfg_n, req, seen}, 3'b100);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule